// File: doc/BRIEF.md
# Extended Register Write-Protect and Strap Controller

This block holds the extended register set of a VGA-compatible display controller: the CRTC extension and configuration registers, two graphics extended-function registers, the high display-start bits, the vertical retrace end register, the miscellaneous output register and the eight CRTC timing registers. Writes arrive as an indexed transfer that names a register space and an index. Every accepted write takes effect at the next clock edge. The stored contents drive the rest of the chip as plain output buses.

Three write guards sit in front of the registers:
- A protect enable gates the sensitive extension registers.
- A clock lock freezes the clock-select and sync-polarity bits of the miscellaneous output register.
- A timing lock freezes the horizontal timing group.

A blocked write is dropped without any error indication. Reads are combinational and always return the stored value, whatever the lock state.

Two configuration registers are loaded from the memory data buses in the first clock cycle after reset is released. A fixed version code, set by a parameter, is read back in the top two bits of the protect register.

Top module: `ext_lock_ctrl`

## Requirements
- R1: While reset is asserted, every stored register reads 0. The exception is the protect register (space 0, index 1Ah), which reads {VERSION, 6'b0}.
- R2: In the first rising clock edge after rst_n goes high, configuration register 1Ch captures strap_bus0 and register 1Dh captures strap_bus1. Later changes on those buses have no effect.
- R3: While bit 4 of CRTC index 1Ah is 0, writes are ignored to CRTC indices 19h and 1Dh and to graphics indices 0Bh and 0Fh. Once that bit is 1, these writes take effect.
- R4: While bit 2 of CRTC index 19h is 1, a write to the miscellaneous output register (space 2) leaves bits 2, 3, 6 and 7 unchanged and updates bits 0, 1, 4 and 5.
- R5: While bit 3 of CRTC index 19h is 1, writes to CRTC indices 00h to 07h are ignored. Other CRTC indices, such as 11h, still accept writes.
- R6: Bits 7:6 of CRTC index 1Ah always read as the VERSION parameter. Writes update only bits 5:0.
- R7: vre_end_out[3:0] equals bits 3:0 of CRTC index 11h. vre_end_out[4] equals bit 6 of index 19h when bit 7 of index 19h is 1, and is 0 otherwise.
- R8: start_hi_out equals bits 2:0 of CRTC index 20h. Index 20h stores only those bits.
- R9: A read returns the stored register value regardless of lock state. Space encoding: 0 is CRTC, 1 is graphics, 2 is miscellaneous output. Unmapped addresses read 0.
- R10: Configuration register 1Ch (CRTC space) accepts writes whether or not the protect bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_space | input | 2 | Register space of the write |
| wr_idx | input | 8 | Register index of the write |
| wr_data | input | 8 | Write data |
| rd_space | input | 2 | Register space of the read |
| rd_idx | input | 8 | Register index of the read |
| rd_data | output | 8 | Combinational read data |
| strap_bus0 | input | 8 | Memory data bus 0, sampled at reset release |
| strap_bus1 | input | 8 | Memory data bus 1, sampled at reset release |
| misc_out | output | 8 | Miscellaneous output register |
| ext1_out | output | 8 | CRTC extension register 1 (index 19h) |
| ext2_out | output | 8 | CRTC extension register 2 with version (index 1Ah) |
| cfg2_out | output | 8 | Configuration register 1Ch |
| cfg3_out | output | 8 | Configuration register 1Dh |
| ef1_out | output | 8 | Graphics extended function 1 (index 0Bh) |
| ef3_out | output | 8 | Graphics extended function 3 (index 0Fh) |
| vre_end_out | output | 5 | Vertical retrace end field |
| start_hi_out | output | 3 | Display start address bits 18:16 |
| timing_out | output | 64 | CRTC timing registers 00h to 07h, index 0 in bits 7:0 |

## Verification
The bench targets the protected registers while they are still locked after reset. A design that ignored the protect bit would overwrite 19h, 1Dh, 0Bh or 0Fh, including the strap-loaded 1Dh value.

The bench also writes all-zero and all-one patterns to the miscellaneous register under clock lock. A wrong keep mask would show up as flipped bits 2, 3, 6 or 7, or as frozen bits 0, 1, 4 or 5. The timing lock is checked at its boundary: index 03h must hold while 11h still updates.

Version bits are written with ones and must read back the parameter. The retrace extension bit is toggled with its enable both clear and set, which catches an output that ignores the enable. Strap buses change right after capture, so a design that kept sampling would drift.

// File: rtl/ext_lock_pkg.sv
package ext_lock_pkg;
  typedef enum logic [1:0] {
    SP_CRTC = 2'd0,
    SP_GFX  = 2'd1,
    SP_MISC = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  localparam logic [7:0] IX_VRE     = 8'h11;
  localparam logic [7:0] IX_EXT1    = 8'h19;
  localparam logic [7:0] IX_EXT2    = 8'h1A;
  localparam logic [7:0] IX_CFG2    = 8'h1C;
  localparam logic [7:0] IX_CFG3    = 8'h1D;
  localparam logic [7:0] IX_STARTHI = 8'h20;
  localparam logic [7:0] IX_EF1     = 8'h0B;
  localparam logic [7:0] IX_EF3     = 8'h0F;

  localparam int PROTECT_BIT  = 4;
  localparam int CLK_LOCK_BIT = 2;
  localparam int TIM_LOCK_BIT = 3;
  localparam int VRE_HI_BIT   = 6;
  localparam int VRE_EN_BIT   = 7;

  localparam logic [7:0] CLK_KEEP_MASK = 8'hCC;
endpackage

// File: rtl/ext_lock_decode.sv
module ext_lock_decode
  import ext_lock_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NUM_TIMING = 8
) (
  input  logic                  wr_en,
  input  logic [1:0]            wr_space,
  input  logic [7:0]            wr_idx,
  input  logic                  protect_on,
  input  logic                  clk_lock,
  input  logic                  tim_lock,
  output logic                  we_ext1,
  output logic                  we_ext2,
  output logic                  we_cfg2,
  output logic                  we_cfg3,
  output logic                  we_ef1,
  output logic                  we_ef3,
  output logic                  we_vre,
  output logic                  we_start,
  output logic                  we_misc,
  output logic [DW-1:0]         misc_keep,
  output logic [NUM_TIMING-1:0] we_tim
);
  logic crtc_hit, gfx_hit;

  always_comb begin
    crtc_hit  = wr_en && (wr_space == SP_CRTC);
    gfx_hit   = wr_en && (wr_space == SP_GFX);
    we_ext1   = crtc_hit && (wr_idx == IX_EXT1) && protect_on;
    we_cfg3   = crtc_hit && (wr_idx == IX_CFG3) && protect_on;
    we_ef1    = gfx_hit  && (wr_idx == IX_EF1)  && protect_on;
    we_ef3    = gfx_hit  && (wr_idx == IX_EF3)  && protect_on;
    we_ext2   = crtc_hit && (wr_idx == IX_EXT2);
    we_cfg2   = crtc_hit && (wr_idx == IX_CFG2);
    we_vre    = crtc_hit && (wr_idx == IX_VRE);
    we_start  = crtc_hit && (wr_idx == IX_STARTHI);
    we_misc   = wr_en && (wr_space == SP_MISC);
    misc_keep = clk_lock ? DW'(CLK_KEEP_MASK) : '0;
  end

  for (genvar g = 0; g < NUM_TIMING; g++) begin : g_tim_we
    assign we_tim[g] = crtc_hit && (wr_idx == 8'(g)) && !tim_lock;
  end
endmodule

// File: rtl/ext_strap_capture.sv
module ext_strap_capture (
  input  logic clk,
  input  logic rst_n,
  output logic load
);
  logic pending_q, pending_d;

  always_comb pending_d = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b1;
    else        pending_q <= pending_d;
  end

  assign load = pending_q;

  a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  a_r2_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q |=> !pending_q);
endmodule

// File: rtl/ext_lock_ctrl.sv
module ext_lock_ctrl
  import ext_lock_pkg::*;
#(
  parameter int                DW         = 8,
  parameter int                NUM_TIMING = 8,
  parameter int                VERSION_W  = 2,
  parameter logic [VERSION_W-1:0] VERSION = 2'd2,
  parameter int                START_HI_W = 3,
  parameter int                VRE_LO_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_space,
  input  logic [7:0]               wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [1:0]               rd_space,
  input  logic [7:0]               rd_idx,
  output logic [DW-1:0]            rd_data,
  input  logic [DW-1:0]            strap_bus0,
  input  logic [DW-1:0]            strap_bus1,
  output logic [DW-1:0]            misc_out,
  output logic [DW-1:0]            ext1_out,
  output logic [DW-1:0]            ext2_out,
  output logic [DW-1:0]            cfg2_out,
  output logic [DW-1:0]            cfg3_out,
  output logic [DW-1:0]            ef1_out,
  output logic [DW-1:0]            ef3_out,
  output logic [VRE_LO_W:0]        vre_end_out,
  output logic [START_HI_W-1:0]    start_hi_out,
  output logic [NUM_TIMING*DW-1:0] timing_out
);
  localparam int EXT2_LO_W = DW - VERSION_W;

  logic [DW-1:0] misc_q, misc_d, ext1_q, ext1_d, cfg2_q, cfg2_d, cfg3_q, cfg3_d;
  logic [DW-1:0] ef1_q, ef1_d, ef3_q, ef3_d, vre_q, vre_d;
  logic [EXT2_LO_W-1:0]  ext2_q, ext2_d;
  logic [START_HI_W-1:0] start_q, start_d;
  logic [DW-1:0] ext2_full;

  logic we_ext1, we_ext2, we_cfg2, we_cfg3, we_ef1, we_ef3, we_vre, we_start, we_misc;
  logic [DW-1:0]         misc_keep;
  logic [NUM_TIMING-1:0] we_tim;
  logic                  strap_load;

  assign ext2_full = {VERSION, ext2_q};

  ext_lock_decode #(.DW(DW), .NUM_TIMING(NUM_TIMING)) u_decode (
    .wr_en     (wr_en),
    .wr_space  (wr_space),
    .wr_idx    (wr_idx),
    .protect_on(ext2_q[PROTECT_BIT]),
    .clk_lock  (ext1_q[CLK_LOCK_BIT]),
    .tim_lock  (ext1_q[TIM_LOCK_BIT]),
    .we_ext1   (we_ext1),
    .we_ext2   (we_ext2),
    .we_cfg2   (we_cfg2),
    .we_cfg3   (we_cfg3),
    .we_ef1    (we_ef1),
    .we_ef3    (we_ef3),
    .we_vre    (we_vre),
    .we_start  (we_start),
    .we_misc   (we_misc),
    .misc_keep (misc_keep),
    .we_tim    (we_tim)
  );

  ext_strap_capture u_strap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (strap_load)
  );

  // next-state
  always_comb begin
    misc_d  = we_misc  ? ((misc_q & misc_keep) | (wr_data & ~misc_keep)) : misc_q;
    ext1_d  = we_ext1  ? wr_data : ext1_q;
    ext2_d  = we_ext2  ? wr_data[EXT2_LO_W-1:0] : ext2_q;
    ef1_d   = we_ef1   ? wr_data : ef1_q;
    ef3_d   = we_ef3   ? wr_data : ef3_q;
    vre_d   = we_vre   ? wr_data : vre_q;
    start_d = we_start ? wr_data[START_HI_W-1:0] : start_q;
    if (strap_load) begin
      cfg2_d = strap_bus0;
      cfg3_d = strap_bus1;
    end else begin
      cfg2_d = we_cfg2 ? wr_data : cfg2_q;
      cfg3_d = we_cfg3 ? wr_data : cfg3_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q  <= '0;
      ext1_q  <= '0;
      ext2_q  <= '0;
      cfg2_q  <= '0;
      cfg3_q  <= '0;
      ef1_q   <= '0;
      ef3_q   <= '0;
      vre_q   <= '0;
      start_q <= '0;
    end else begin
      misc_q  <= misc_d;
      ext1_q  <= ext1_d;
      ext2_q  <= ext2_d;
      cfg2_q  <= cfg2_d;
      cfg3_q  <= cfg3_d;
      ef1_q   <= ef1_d;
      ef3_q   <= ef3_d;
      vre_q   <= vre_d;
      start_q <= start_d;
    end
  end

  // timing register group
  logic [DW-1:0] tim_q [NUM_TIMING];
  for (genvar g = 0; g < NUM_TIMING; g++) begin : g_tim
    logic [DW-1:0] tim_d;
    always_comb tim_d = we_tim[g] ? wr_data : tim_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim_q[g] <= '0;
      else        tim_q[g] <= tim_d;
    end
    assign timing_out[g*DW +: DW] = tim_q[g];
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_space)
      SP_CRTC: begin
        if (rd_idx < 8'(NUM_TIMING)) rd_data = tim_q[rd_idx[$clog2(NUM_TIMING)-1:0]];
        else begin
          case (rd_idx)
            IX_VRE:     rd_data = vre_q;
            IX_EXT1:    rd_data = ext1_q;
            IX_EXT2:    rd_data = ext2_full;
            IX_CFG2:    rd_data = cfg2_q;
            IX_CFG3:    rd_data = cfg3_q;
            IX_STARTHI: rd_data = DW'(start_q);
            default:    rd_data = '0;
          endcase
        end
      end
      SP_GFX: begin
        case (rd_idx)
          IX_EF1:  rd_data = ef1_q;
          IX_EF3:  rd_data = ef3_q;
          default: rd_data = '0;
        endcase
      end
      SP_MISC: rd_data = misc_q;
      default: rd_data = '0;
    endcase
  end

  assign misc_out     = misc_q;
  assign ext1_out     = ext1_q;
  assign ext2_out     = ext2_full;
  assign cfg2_out     = cfg2_q;
  assign cfg3_out     = cfg3_q;
  assign ef1_out      = ef1_q;
  assign ef3_out      = ef3_q;
  assign start_hi_out = start_q;
  assign vre_end_out  = {ext1_q[VRE_EN_BIT] & ext1_q[VRE_HI_BIT], vre_q[VRE_LO_W-1:0]};

  // protection checks
  a_r3_ext1_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !ext2_q[PROTECT_BIT] |=> ext1_q == $past(ext1_q));
  a_r3_gfx_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !ext2_q[PROTECT_BIT] |=> (ef1_q == $past(ef1_q)) && (ef3_q == $past(ef3_q)));
  a_r3_cfg3_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext2_q[PROTECT_BIT] && !strap_load) |=> cfg3_q == $past(cfg3_q));
  a_r4_clock_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ext1_q[CLK_LOCK_BIT] |=> (misc_q & DW'(CLK_KEEP_MASK)) == ($past(misc_q) & DW'(CLK_KEEP_MASK)));
  a_r5_timing_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ext1_q[TIM_LOCK_BIT] |=> $stable(timing_out));
  a_r6_version: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_space == SP_CRTC) && (rd_idx == IX_EXT2)) |-> rd_data[DW-1:EXT2_LO_W] == VERSION);
  a_r2_strap_load: assert property (@(posedge clk) disable iff (!rst_n)
    strap_load |=> (cfg2_q == $past(strap_bus0)) && (cfg3_q == $past(strap_bus1)));
endmodule

// File: tb/ext_lock_ctrl_tb.sv
module ext_lock_ctrl_tb;
  localparam logic [1:0] VER = 2'd2;
  localparam logic [1:0] CR = 2'd0, GF = 2'd1, MS = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_space = 2'd0, rd_space = 2'd0;
  logic [7:0]  wr_idx = 8'd0, wr_data = 8'd0, rd_idx = 8'd0;
  logic [7:0]  strap_bus0 = 8'hA5, strap_bus1 = 8'h3C;
  logic [7:0]  rd_data, misc_out, ext1_out, ext2_out, cfg2_out, cfg3_out, ef1_out, ef3_out;
  logic [4:0]  vre_end_out;
  logic [2:0]  start_hi_out;
  logic [63:0] timing_out;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int    q_src[$];
  int    q_addr[$];
  int    q_exp[$];
  string q_tag[$];

  always #10 clk = ~clk;

  ext_lock_ctrl #(.VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_space(wr_space), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_space(rd_space), .rd_idx(rd_idx), .rd_data(rd_data),
    .strap_bus0(strap_bus0), .strap_bus1(strap_bus1), .misc_out(misc_out),
    .ext1_out(ext1_out), .ext2_out(ext2_out), .cfg2_out(cfg2_out), .cfg3_out(cfg3_out),
    .ef1_out(ef1_out), .ef3_out(ef3_out), .vre_end_out(vre_end_out),
    .start_hi_out(start_hi_out), .timing_out(timing_out)
  );

  task automatic wr(input logic [1:0] sp, input logic [7:0] ix, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_space = sp; wr_idx = ix; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // src 0: rd_data at (sp, ix); 1: vre_end_out; 2: start_hi_out; 3: misc_out; 4: timing byte
  task automatic expect_val(input int src, input logic [1:0] sp, input logic [7:0] ix,
                            input int exp, input string tag);
    @(negedge clk);
    rd_space = sp; rd_idx = ix;
    #2;
    q_src.push_back(src); q_addr.push_back(int'(ix)); q_exp.push_back(exp); q_tag.push_back(tag);
  endtask

  task automatic rd_chk(input logic [1:0] sp, input logic [7:0] ix, input int exp, input string tag);
    expect_val(0, sp, ix, exp, tag);
  endtask

  initial begin : monitor
    forever begin
      int src, addr, exp, act;
      string tag;
      wait (q_exp.size() > 0);
      src = q_src.pop_front(); addr = q_addr.pop_front();
      exp = q_exp.pop_front(); tag = q_tag.pop_front();
      case (src)
        0: act = int'(rd_data);
        1: act = int'(vre_end_out);
        2: act = int'(start_hi_out);
        3: act = int'(misc_out);
        default: act = int'(timing_out[addr*8 +: 8]);
      endcase
      compared++;
      if (act != exp) begin
        mismatched++;
        $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset state
    repeat (3) @(negedge clk);
    rd_chk(MS, 8'h00, 8'h00, "R1 misc");
    rd_chk(CR, 8'h19, 8'h00, "R1 ext1");
    rd_chk(CR, 8'h1A, {VER, 6'b0}, "R1 ext2 version");
    rd_chk(CR, 8'h1C, 8'h00, "R1 cfg2 before release");
    // R2: strap capture at release
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); strap_bus0 = 8'h5A; strap_bus1 = 8'hC3;
    rd_chk(CR, 8'h1C, 8'hA5, "R2 cfg2 strap");
    rd_chk(CR, 8'h1D, 8'h3C, "R2 cfg3 strap");
    repeat (3) @(negedge clk);
    rd_chk(CR, 8'h1C, 8'hA5, "R2 cfg2 held after bus change");
    // R3: protected registers locked
    wr(CR, 8'h19, 8'hFF);  rd_chk(CR, 8'h19, 8'h00, "R3 ext1 locked");
    wr(GF, 8'h0B, 8'h55);  rd_chk(GF, 8'h0B, 8'h00, "R3 ef1 locked");
    wr(GF, 8'h0F, 8'hAA);  rd_chk(GF, 8'h0F, 8'h00, "R3 ef3 locked");
    wr(CR, 8'h1D, 8'h00);  rd_chk(CR, 8'h1D, 8'h3C, "R3 cfg3 locked");
    // R10
    wr(CR, 8'h1C, 8'h12);  rd_chk(CR, 8'h1C, 8'h12, "R10 cfg2 writable");
    // R6
    wr(CR, 8'h1A, 8'hFF);  rd_chk(CR, 8'h1A, {VER, 6'h3F}, "R6 version kept");
    // R3: unlocked
    wr(CR, 8'h19, 8'h00);  rd_chk(CR, 8'h19, 8'h00, "R3 ext1 open");
    wr(GF, 8'h0B, 8'h55);  rd_chk(GF, 8'h0B, 8'h55, "R3 ef1 open");
    wr(GF, 8'h0F, 8'hAA);  rd_chk(GF, 8'h0F, 8'hAA, "R3 ef3 open");
    wr(CR, 8'h1D, 8'h81);  rd_chk(CR, 8'h1D, 8'h81, "R3 cfg3 open");
    // R5: timing regs writable when unlocked
    for (int i = 0; i < 8; i++) wr(CR, 8'(i), 8'(8'h11 * i + 1));
    for (int i = 0; i < 8; i++) expect_val(4, CR, 8'(i), 8'h11 * i + 1, "R5 timing open");
    rd_chk(CR, 8'h07, 8'h78, "R9 timing read");
    // R4: clock lock
    wr(MS, 8'h00, 8'hFF);  expect_val(3, MS, 8'h00, 8'hFF, "R4 misc unlocked");
    wr(CR, 8'h19, 8'h04);
    wr(MS, 8'h00, 8'h00);  expect_val(3, MS, 8'h00, 8'hCC, "R4 misc locked zeros");
    wr(MS, 8'h00, 8'h33);  expect_val(3, MS, 8'h00, 8'hFF, "R4 misc locked ones");
    wr(CR, 8'h19, 8'h00);
    wr(MS, 8'h00, 8'h00);  rd_chk(MS, 8'h00, 8'h00, "R4 misc after unlock");
    // R5: timing lock
    wr(CR, 8'h19, 8'h08);
    wr(CR, 8'h03, 8'hEE);  expect_val(4, CR, 8'h03, 8'h34, "R5 timing locked");
    rd_chk(CR, 8'h03, 8'h34, "R9 read under lock");
    wr(CR, 8'h11, 8'h0A);  rd_chk(CR, 8'h11, 8'h0A, "R5 index 11h still open");
    // R8
    wr(CR, 8'h20, 8'hFF);
    expect_val(2, CR, 8'h20, 7, "R8 start_hi");
    rd_chk(CR, 8'h20, 8'h07, "R8 start_hi stored bits");
    // R7
    wr(CR, 8'h19, 8'h48);  expect_val(1, CR, 8'h00, 8'h0A, "R7 ext bit without enable");
    wr(CR, 8'h19, 8'hC8);  expect_val(1, CR, 8'h00, 8'h1A, "R7 ext bit enabled");
    wr(CR, 8'h19, 8'h88);  expect_val(1, CR, 8'h00, 8'h0A, "R7 enable with bit clear");
    // R3 relock
    wr(CR, 8'h1A, 8'h00);  rd_chk(CR, 8'h1A, {VER, 6'h00}, "R6 low bits cleared");
    wr(CR, 8'h19, 8'h00);  rd_chk(CR, 8'h19, 8'h88, "R3 ext1 relocked");
    @(negedge clk);
    wait (q_exp.size() == 0);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule